// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Use and Dirty Tracking

This block caches page translations for a processor's memory pipeline. A lookup presents a 48-bit virtual address, which is a 36-bit virtual page number above a 12-bit page offset, together with a read or write flag. All stored tags are compared with the page number at once. In the same cycle the block answers with a hit flag, a 45-bit physical address, a protection-fault flag, a miss flag and the entry's dirty status. On a miss, an external page-table walker or software supplies the translation through the refill port.

Each entry holds its own use and dirty bits, and the block keeps them up to date. Any hit marks the entry as used. A permitted write hit marks it dirty. A single-cycle clear input wipes every use bit. Issued at intervals, it gives a cheap approximation of least-recently-used order. The refill slot is offered on a port at all times. It is the lowest free slot first, then the lowest slot not used since the last clear, and only when every slot is valid and used, a slot named by a rotating pointer.

Top module: `tlb_ref`

## Requirements
- R1: After a synchronous active-low reset every entry is invalid, so every lookup misses, and the offered refill slot is 0.
- R2: On a hit, `lk_paddr` is the entry's 33-bit physical page number in bits 44:12, with the lookup's 12-bit offset copied unchanged into bits 11:0.
- R3: When `lk_valid` is high and the virtual page number (bits 47:12 of `lk_vaddr`) equals the tag of a valid entry, `lk_hit` is high in that same cycle and `lk_miss` is low.
- R4: When `lk_valid` is high and no valid entry matches, `lk_miss` is high, and `lk_hit`, `lk_fault`, `lk_dirty` and `lk_paddr` are zero. When `lk_valid` is low, all lookup outputs are zero.
- R5: A refill writes the tag, page number and protection into the offered slot and sets valid and use and clears dirty, all on the clock edge. A lookup of that page hits from the next cycle on.
- R6: A hit sets the entry's use bit. A write hit that does not fault sets its dirty bit. `lk_dirty` shows the dirty bit as it stood before the access.
- R7: The 2-bit protection field has bit 1 as read permission and bit 0 as write permission. A hit whose access lacks its permission bit raises `lk_fault` and leaves the dirty bit unchanged. A hit that has its permission bit does not fault.
- R8: While any entry is invalid, `victim_idx` is the lowest-numbered invalid entry.
- R9: While all entries are valid and at least one has its use bit clear, `victim_idx` is the lowest-numbered entry with a clear use bit.
- R10: While all entries are valid and used, `victim_idx` is a rotating pointer. The pointer is 0 after reset and advances by one, wrapping after the last entry, on each refill that takes the pointer's slot.
- R11: `use_clear` clears every use bit on the clock edge. A use bit set in the same cycle by a refill or a hit stays set.
- R12: The entry count is a parameter, 64 by default. With 64 entries filled, a further refill evicts one translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is a write (1) or a read (0) |
| lk_vaddr | input | 48 | Virtual address: page number 47:12, offset 11:0 |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Lookup found no translation |
| lk_fault | output | 1 | Access type not permitted by the hit entry |
| lk_dirty | output | 1 | Dirty bit of the hit entry before this access |
| lk_paddr | output | 45 | Physical address: page number 44:12, offset 11:0 |
| fill_en | input | 1 | Install a translation into `victim_idx` this cycle |
| fill_vpn | input | 36 | Virtual page number of the new entry |
| fill_ppn | input | 33 | Physical page number of the new entry |
| fill_prot | input | 2 | Protection: bit 1 read allowed, bit 0 write allowed |
| use_clear | input | 1 | Clear all use bits this cycle |
| victim_idx | output | 6 | Slot the next refill will write |

## Verification
The assertions assume that a page number is never installed while it is already resident. Under that assumption at most one tag can match, and the single-match and dirty checks rely on it. The stimulus keeps to this rule: before each refill the bench looks the page up in its own model and raises `fill_en` only for a page that the model does not hold. Lookups, clears and refills are mixed freely in the same cycle, since the block handles every such collision itself.

// File: rtl/tlb_ref_pkg.sv
// Package: shared constants and types for the translation buffer.
// Assumes a fixed 12-bit page offset and a 2-bit protection field.
package tlb_ref_pkg;
    localparam int unsigned OFF_W   = 12;
    localparam int unsigned PROT_W  = 2;
    localparam int unsigned PROT_RD = 1;   // read permission bit
    localparam int unsigned PROT_WR = 0;   // write permission bit

    // Which rule picked the refill slot
    typedef enum logic [1:0] {
        VSRC_FREE   = 2'd0,
        VSRC_STALE  = 2'd1,
        VSRC_ROTATE = 2'd2
    } vsrc_e;
endpackage

// File: rtl/tlb_ref_store.sv
// Entry storage: tag, physical page, protection, valid, use and dirty per
// entry. A refill overrides a same-cycle hit update on the same slot; a hit
// or refill use-bit set overrides a same-cycle global clear.
// Assumes fill_oh and touch_oh are each zero or one-hot.
module tlb_ref_store
    import tlb_ref_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned VPN_W   = 36,
    parameter int unsigned PPN_W   = 33
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ENTRIES-1:0]  touch_oh,
    input  logic                set_dirty,
    input  logic                use_clear,
    input  logic [ENTRIES-1:0]  fill_oh,
    input  logic [VPN_W-1:0]    fill_vpn,
    input  logic [PPN_W-1:0]    fill_ppn,
    input  logic [PROT_W-1:0]   fill_prot,
    output logic [VPN_W-1:0]    tag_q  [ENTRIES],
    output logic [PPN_W-1:0]    ppn_q  [ENTRIES],
    output logic [PROT_W-1:0]   prot_q [ENTRIES],
    output logic [ENTRIES-1:0]  valid_q,
    output logic [ENTRIES-1:0]  use_q,
    output logic [ENTRIES-1:0]  dirty_q
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        // Translation payload: written only by a refill
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[g]  <= '0;
                ppn_q[g]  <= '0;
                prot_q[g] <= '0;
            end else if (fill_oh[g]) begin
                tag_q[g]  <= fill_vpn;
                ppn_q[g]  <= fill_ppn;
                prot_q[g] <= fill_prot;
            end
        end

        // Valid bit: cleared by reset, set by a refill
        always_ff @(posedge clk) begin
            if (!rst_n)          valid_q[g] <= 1'b0;
            else if (fill_oh[g]) valid_q[g] <= 1'b1;
        end

        // Use bit: refill or hit sets it, the global clear drops it otherwise
        always_ff @(posedge clk) begin
            if (!rst_n)                     use_q[g] <= 1'b0;
            else if (fill_oh[g] || touch_oh[g]) use_q[g] <= 1'b1;
            else if (use_clear)             use_q[g] <= 1'b0;
        end

        // Dirty bit: refill clears it, a permitted write hit sets it
        always_ff @(posedge clk) begin
            if (!rst_n)                          dirty_q[g] <= 1'b0;
            else if (fill_oh[g])                 dirty_q[g] <= 1'b0;
            else if (set_dirty && touch_oh[g])   dirty_q[g] <= 1'b1;
        end
    end

    // R5: a refilled slot is valid, used and clean on the next cycle
    p_fill_fresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|fill_oh) |=> ((valid_q & use_q & ~dirty_q & $past(fill_oh)) == $past(fill_oh)));

    // R11: a clear with no refill and no hit leaves no use bit set
    p_clear_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (use_clear && !(|fill_oh) && !(|touch_oh)) |=> (use_q == '0));

    // R6: a dirty bit only rises on the entry that was hit
    p_dirty_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|fill_oh)) |=> ((dirty_q & ~$past(dirty_q) & ~$past(touch_oh)) == '0));

endmodule

// File: rtl/tlb_ref_match.sv
// Parallel tag compare: one comparator per entry, then a one-hot to index
// encoder for the data select.
// Assumes no page number is resident in two entries at once.
module tlb_ref_match #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned VPN_W   = 36,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [VPN_W-1:0]    look_vpn,
    input  logic [VPN_W-1:0]    tag_q [ENTRIES],
    input  logic [ENTRIES-1:0]  valid_q,
    output logic [ENTRIES-1:0]  match_oh,
    output logic                any_match,
    output logic [IDX_W-1:0]    match_idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        // Per-entry comparator gated by the valid bit
        assign match_oh[g] = valid_q[g] && (tag_q[g] == look_vpn);
    end

    assign any_match = |match_oh;

    // Encode the one-hot match into an index by OR-ing the matching positions
    always_comb begin
        match_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (match_oh[i]) match_idx = match_idx | IDX_W'(i);
    end

    // R3: with unique tags, at most one entry matches
    p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_oh));

endmodule

// File: rtl/tlb_ref_victim.sv
// Refill slot choice: lowest invalid slot, else lowest slot with a clear use
// bit, else a rotating pointer that advances when a refill takes its slot.
// Assumes ENTRIES is at least 2.
module tlb_ref_victim
    import tlb_ref_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ENTRIES-1:0]  valid_q,
    input  logic [ENTRIES-1:0]  use_q,
    input  logic                fill_en,
    output logic [IDX_W-1:0]    victim_idx,
    output logic [ENTRIES-1:0]  victim_oh
);

    logic [IDX_W-1:0] ptr_q;
    vsrc_e            src;

    // Priority encoder favouring the lowest-numbered set bit
    function automatic logic [IDX_W-1:0] lowest_set(input logic [ENTRIES-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (v[i]) r = IDX_W'(i);
        return r;
    endfunction

    // Pick the slot by the three-level preference
    always_comb begin
        if (!(&valid_q)) begin
            src        = VSRC_FREE;
            victim_idx = lowest_set(~valid_q);
        end else if (!(&use_q)) begin
            src        = VSRC_STALE;
            victim_idx = lowest_set(~use_q);
        end else begin
            src        = VSRC_ROTATE;
            victim_idx = ptr_q;
        end
    end

    assign victim_oh = ENTRIES'(1) << victim_idx;

    // Rotating pointer: steps only when a refill consumed the pointer slot
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (fill_en && src == VSRC_ROTATE)
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end

    // R8: with a free slot available, the offered slot is free
    p_free_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&valid_q)) |-> !valid_q[victim_idx]);

    // R9: with all valid and some unused, the offered slot is unused
    p_stale_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((&valid_q) && !(&use_q)) |-> !use_q[victim_idx]);

endmodule

// File: rtl/tlb_ref.sv
// Fully associative translation buffer top: combinational lookup against
// all entries, protection check, use/dirty maintenance and refill into the
// offered victim slot.
// Assumes refills never install a page number that is already resident.
module tlb_ref
    import tlb_ref_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned VPN_W   = 36,
    parameter int unsigned PPN_W   = 33,
    localparam int unsigned VA_W   = VPN_W + OFF_W,
    localparam int unsigned PA_W   = PPN_W + OFF_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic              lk_dirty,
    output logic [PA_W-1:0]   lk_paddr,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PROT_W-1:0] fill_prot,
    input  logic              use_clear,
    output logic [IDX_W-1:0]  victim_idx
);

    logic [VPN_W-1:0]   tag_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    logic [PROT_W-1:0]  prot_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q, use_q, dirty_q;
    logic [ENTRIES-1:0] match_oh, touch_oh, fill_oh, victim_oh;
    logic               any_match, perm_ok, set_dirty;
    logic [IDX_W-1:0]   hit_idx;
    logic [PPN_W-1:0]   sel_ppn;
    logic [PROT_W-1:0]  sel_prot;

    tlb_ref_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_vpn  (lk_vaddr[VA_W-1:OFF_W]),
        .tag_q     (tag_q),
        .valid_q   (valid_q),
        .match_oh  (match_oh),
        .any_match (any_match),
        .match_idx (hit_idx)
    );

    tlb_ref_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_q    (valid_q),
        .use_q      (use_q),
        .fill_en    (fill_en),
        .victim_idx (victim_idx),
        .victim_oh  (victim_oh)
    );

    tlb_ref_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_oh  (touch_oh),
        .set_dirty (set_dirty),
        .use_clear (use_clear),
        .fill_oh   (fill_oh),
        .fill_vpn  (fill_vpn),
        .fill_ppn  (fill_ppn),
        .fill_prot (fill_prot),
        .tag_q     (tag_q),
        .ppn_q     (ppn_q),
        .prot_q    (prot_q),
        .valid_q   (valid_q),
        .use_q     (use_q),
        .dirty_q   (dirty_q)
    );

    // Select the hit entry's payload and apply the permission check
    always_comb begin
        sel_ppn   = ppn_q[hit_idx];
        sel_prot  = prot_q[hit_idx];
        lk_hit    = lk_valid && any_match;
        lk_miss   = lk_valid && !any_match;
        perm_ok   = lk_write ? sel_prot[PROT_WR] : sel_prot[PROT_RD];
        lk_fault  = lk_hit && !perm_ok;
        set_dirty = lk_hit && lk_write && perm_ok;
        lk_dirty  = lk_hit && dirty_q[hit_idx];
        lk_paddr  = lk_hit ? {sel_ppn, lk_vaddr[OFF_W-1:0]} : '0;
        touch_oh  = lk_hit ? match_oh : '0;
        fill_oh   = fill_en ? victim_oh : '0;
    end

    // R4: hit and miss never assert together
    p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    // R2: the page offset is carried straight through on a hit
    p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    // R7: a faulting access leaves the entry's dirty bit as it was
    p_fault_keeps_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault && !fill_en) |=> (dirty_q[$past(hit_idx)] == $past(dirty_q[hit_idx])));

    // R6: a permitted write hit leaves its entry dirty
    p_write_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_write && !lk_fault && !fill_en) |=> dirty_q[$past(hit_idx)]);

endmodule

// File: tb/test_tlb_ref.sv
// Bench: behavioural model of the buffer (plain arrays, linear search)
// compared with every output of the design on every clock.
module test_tlb_ref;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_write;
    logic [47:0] lk_vaddr;
    logic        lk_hit, lk_miss, lk_fault, lk_dirty;
    logic [44:0] lk_paddr;
    logic        fill_en;
    logic [35:0] fill_vpn;
    logic [32:0] fill_ppn;
    logic [1:0]  fill_prot;
    logic        use_clear;
    logic [5:0]  victim_idx;

    always #10 clk = ~clk;   // 50 MHz

    tlb_ref i_tlb_ref (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
        .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_fault(lk_fault), .lk_dirty(lk_dirty), .lk_paddr(lk_paddr),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_prot(fill_prot), .use_clear(use_clear), .victim_idx(victim_idx)
    );

    // Model state
    logic [35:0] m_tag [N];
    logic [32:0] m_ppn [N];
    logic [1:0]  m_prot[N];
    bit          m_v[N], m_u[N], m_d[N];
    int          m_ptr;
    int          checks = 0, fails = 0;

    function automatic logic [35:0] vk(int k);
        return 36'(k) * 36'h0_0123_4567 + 36'h9;
    endfunction

    function automatic int m_find(logic [35:0] vpn);
        for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == vpn) return i;
        return -1;
    endfunction

    function automatic int m_victim(output bit rot);
        rot = 1'b0;
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        for (int i = 0; i < N; i++) if (!m_u[i]) return i;
        rot = 1'b1;
        return m_ptr;
    endfunction

    task automatic chk(bit ok, string ctx, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s/%s %s act=%0h exp=%0h", ctx, tag, what, act, exp);
        end
    endtask

    // Compare all outputs mid-cycle, then advance the model over the edge
    task automatic cycle(string ctx);
        int idx, vic;
        bit rot, e_hit, e_miss, e_fault, e_dirty, ok_perm;
        logic [44:0] e_pa;
        #5;
        idx = lk_valid ? m_find(lk_vaddr[47:12]) : -1;
        e_hit = (idx >= 0); e_miss = lk_valid && idx < 0;
        e_fault = 1'b0; e_dirty = 1'b0; e_pa = '0; ok_perm = 1'b0;
        if (e_hit) begin
            ok_perm = lk_write ? m_prot[idx][0] : m_prot[idx][1];
            e_fault = !ok_perm;
            e_dirty = m_d[idx];
            e_pa    = {m_ppn[idx], lk_vaddr[11:0]};
        end
        vic = m_victim(rot);
        chk(lk_hit == e_hit, ctx, "R3", "lk_hit", lk_hit, e_hit);
        chk(lk_miss == e_miss, ctx, "R4", "lk_miss", lk_miss, e_miss);
        chk(lk_fault == e_fault, ctx, "R7", "lk_fault", lk_fault, e_fault);
        chk(lk_dirty == e_dirty, ctx, "R6", "lk_dirty", lk_dirty, e_dirty);
        chk(lk_paddr == e_pa, ctx, "R2", "lk_paddr", lk_paddr, e_pa);
        chk(int'(victim_idx) == vic, ctx, "R8", "victim_idx", victim_idx, vic);
        @(posedge clk);
        #1;
        if (use_clear) for (int i = 0; i < N; i++) m_u[i] = 1'b0;
        if (e_hit) begin
            m_u[idx] = 1'b1;
            if (lk_write && ok_perm) m_d[idx] = 1'b1;
        end
        if (fill_en) begin
            m_tag[vic] = fill_vpn; m_ppn[vic] = fill_ppn; m_prot[vic] = fill_prot;
            m_v[vic] = 1'b1; m_u[vic] = 1'b1; m_d[vic] = 1'b0;
            if (rot) m_ptr = (m_ptr + 1) % N;
        end
        @(negedge clk);
    endtask

    task automatic drive(bit lv, bit wr, logic [35:0] vpn, logic [11:0] off,
                         bit fe, logic [35:0] fv, logic [32:0] fp, logic [1:0] fpr,
                         bit clr, string ctx);
        lk_valid = lv; lk_write = wr; lk_vaddr = {vpn, off};
        fill_en = fe; fill_vpn = fv; fill_ppn = fp; fill_prot = fpr;
        use_clear = clr;
        cycle(ctx);
    endtask

    task automatic look(int k, bit wr, logic [11:0] off, string ctx);
        drive(1'b1, wr, vk(k), off, 1'b0, '0, '0, '0, 1'b0, ctx);
    endtask

    task automatic fill(int k, logic [1:0] prot, bit clr, string ctx);
        drive(1'b0, 1'b0, '0, '0, 1'b1, vk(k), 33'(k) * 33'h1_0003 + 33'h1_2345_6789, prot, clr, ctx);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_u[i] = 0; m_d[i] = 0; m_tag[i] = '0; m_ppn[i] = '0; m_prot[i] = '0;
        end
        m_ptr = 0;
        rst_n = 1'b0; lk_valid = 0; lk_write = 0; lk_vaddr = '0;
        fill_en = 0; fill_vpn = '0; fill_ppn = '0; fill_prot = '0; use_clear = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        look(0, 1'b0, 12'h000, "R1");               // empty buffer misses, victim 0
        look(5, 1'b1, 12'h123, "R1");
        fill(0, 2'b11, 1'b0, "R5");                  // slot 0, read/write
        look(0, 1'b0, 12'hABC, "R3");                // hit, offset passes
        look(0, 1'b0, 12'hFFF, "R2");
        fill(1, 2'b10, 1'b0, "R8");                  // slot 1, read-only
        look(1, 1'b1, 12'h010, "R7");                // write to read-only faults
        look(1, 1'b0, 12'h011, "R7");                // dirty unchanged, read ok
        look(0, 1'b1, 12'h020, "R6");                // write marks dirty
        look(0, 1'b0, 12'h021, "R6");
        fill(2, 2'b01, 1'b0, "R8");                  // write-only
        look(2, 1'b0, 12'h030, "R7");                // read faults
        for (int k = 3; k < N; k++) fill(k, 2'b11, 1'b0, "R8");
        look(3, 1'b0, 12'h040, "R10");               // all used: pointer slot 0
        fill(64, 2'b11, 1'b0, "R10");                // evicts slot 0
        look(0, 1'b0, 12'h050, "R12");               // evicted page now misses
        fill(65, 2'b11, 1'b0, "R10");                // pointer slot 1
        drive(1'b0, 1'b0, '0, '0, 1'b0, '0, '0, '0, 1'b1, "R11");
        look(64, 1'b0, 12'h060, "R9");               // slot 0 used again
        look(65, 1'b0, 12'h061, "R9");               // victim now slot 2
        fill(66, 2'b11, 1'b1, "R11");                // clear + refill slot 2
        drive(1'b0, 1'b0, '0, '0, 1'b0, '0, '0, '0, 1'b0, "R11");
        drive(1'b1, 1'b0, vk(64), 12'h070, 1'b0, '0, '0, '0, 1'b1, "R11");
        drive(1'b0, 1'b0, '0, '0, 1'b0, '0, '0, '0, 1'b0, "R4");

        // Mixed traffic with unique-page refills only
        for (int n = 0; n < 600; n++) begin
            int  k  = $urandom_range(0, 95);
            int  kf = $urandom_range(0, 95);
            bit  fe = ($urandom_range(0, 3) == 0) && (m_find(vk(kf)) < 0);
            drive($urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)), vk(k),
                  12'($urandom_range(0, 4095)), fe, vk(kf),
                  33'($urandom()) ^ 33'h1_0000_0000, 2'($urandom_range(0, 3)),
                  $urandom_range(0, 15) == 0, "mix");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule